// File: doc/BRIEF.md
# Interrupt Priority Level Resolver

The resolver merges sixteen external interrupt level lines with a software interrupt register. It picks the highest pending level that the processor interrupt level mask allows. It holds the result as a registered external-interrupt trap code together with a hard request flag. Two timer bits in the software register both fold onto level 14. A mode input selects one of two ways of masking level 15: in one mode level 15 cannot be masked, and in the other it obeys the same rule as every other level.

A new request is not raised while a trap of higher numeric type is being serviced at a nonzero trap level. A new request is also not raised while interrupts are globally disabled. When nothing is pending, a held request is withdrawn. The trap unit raises an acknowledge input. If the held code may be delivered at that moment, the block answers with a one-cycle take strobe on the next cycle.

Top module: `irq_level_resolver`

## Requirements
- R1: While rst_ni is low, code_o is 0x00, and req_o and take_o are 0.
- R2: The pending vector is the OR of ext_lvl_i and softint_i[15:0]. Softint bits 0 and 16 are excluded from this direct OR. Pending bit 0 is always ignored. For example, ext_lvl_i[0] alone counts as nothing pending, and softint_i[7] pends level 7.
- R3: If softint_i bit 0 (tick timer) or bit 16 (system timer) is set, level 14 is pending.
- R4: The block scans levels from 15 down to 1. The highest pending level L with L > pil_i wins. One cycle later code_o = {4'h4, L} and req_o = 1.
- R5: With v8_mode_i = 1, level 15 is eligible whatever pil_i is. With v8_mode_i = 0, level 15 needs 15 > pil_i, so pil_i = 15 masks it.
- R6: While int_en_i = 0, code_o and req_o keep their values when a level is pending.
- R7: If trap_lvl_i != 0 and cur_tt_i > {1'b0, new code}, code_o and req_o keep their values. If cur_tt_i is not greater, or trap_lvl_i = 0, the update proceeds.
- R8: If nothing is pending and req_o = 1, then on the next cycle code_o = 0x00 and req_o = 0.
- R9: take_o is 1 exactly in the cycle after a cycle in which all of these hold: ack_i = 1, req_o = 1, int_en_i = 1, code_o != 0, and the level code_o[3:0] is eligible under the pil_i/v8_mode_i rule of R4/R5.
- R10: If levels are pending but none is eligible, code_o and req_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_lvl_i | input | 16 | External interrupt level lines |
| softint_i | input | 17 | Software interrupt register (bit 0 tick timer, bit 16 system timer) |
| pil_i | input | 4 | Processor interrupt level mask |
| int_en_i | input | 1 | Global interrupt enable |
| v8_mode_i | input | 1 | 1: level 15 unmaskable; 0: level 15 maskable |
| trap_lvl_i | input | 3 | Current trap level |
| cur_tt_i | input | 9 | Trap type being serviced |
| ack_i | input | 1 | Delivery acknowledge from trap unit |
| code_o | output | 8 | Held trap code |
| req_o | output | 1 | Hard interrupt request |
| take_o | output | 1 | One-cycle delivery strobe |

## Verification
A corrupted held code or request flag shows at code_o and req_o one cycle after the offending edge. Because the state only changes when the selected code differs, a stale value can persist. It stays visible until a different level wins or the pending vector empties. A wrong delivery decision appears on take_o one cycle after ack_i. The reference model mirrors each edge, so any divergence is reported at the very next sample.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int unsigned NUM_LVL   = 16;
  localparam int unsigned LVL_W     = $clog2(NUM_LVL);
  localparam int unsigned SOFT_W    = 17;
  localparam int unsigned TICK_BIT  = 0;
  localparam int unsigned STICK_BIT = 16;
  localparam int unsigned TIMER_LVL = 14;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned TT_W      = 9;
  localparam logic [CODE_W-LVL_W-1:0] EXT_TT = 4'h4;
endpackage

// File: rtl/irq_merge.sv
module irq_merge
  import irq_res_pkg::*;
(
  input  logic [NUM_LVL-1:0] ext_lvl_i,
  input  logic [SOFT_W-1:0]  softint_i,
  output logic [NUM_LVL-1:0] pend_o
);
  localparam logic [SOFT_W-1:0] TIMER_MASK =
    (SOFT_W'(1) << TICK_BIT) | (SOFT_W'(1) << STICK_BIT);

  logic [SOFT_W-1:0]  soft_direct;
  logic               timer_hit;
  logic [NUM_LVL-1:0] merged;

  always_comb begin
    soft_direct = softint_i & ~TIMER_MASK;
    timer_hit   = |(softint_i & TIMER_MASK);
    merged      = ext_lvl_i | soft_direct[NUM_LVL-1:0];
    merged[TIMER_LVL] = merged[TIMER_LVL] | timer_hit;
    merged[0]   = 1'b0;  // level 0 is never an interrupt
    pend_o      = merged;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_res_pkg::*;
(
  input  logic [NUM_LVL-1:0] pend_i,
  input  logic [LVL_W-1:0]   pil_i,
  input  logic               v8_mode_i,
  output logic               hit_o,
  output logic [LVL_W-1:0]   lvl_o
);
  logic [NUM_LVL-1:0] elig;

  assign elig[0] = 1'b0;
  for (genvar i = 1; i < NUM_LVL; i++) begin : g_elig
    if (i == NUM_LVL - 1) begin : g_top
      assign elig[i] = pend_i[i] & ((LVL_W'(i) > pil_i) | v8_mode_i);
    end else begin : g_norm
      assign elig[i] = pend_i[i] & (LVL_W'(i) > pil_i);
    end
  end

  always_comb begin
    lvl_o = '0;
    for (int i = 1; i < NUM_LVL; i++) begin
      if (elig[i]) lvl_o = LVL_W'(i);  // later (higher) wins
    end
    hit_o = |elig;
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_res_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              req_i,
  input  logic              ack_i,
  input  logic              int_en_i,
  input  logic [LVL_W-1:0]  pil_i,
  input  logic              v8_mode_i,
  output logic              take_o
);
  logic [LVL_W-1:0] lvl;
  logic             allowed;

  always_comb begin
    lvl     = code_i[LVL_W-1:0];
    allowed = (lvl > pil_i) | (v8_mode_i & (lvl == LVL_W'(NUM_LVL - 1)));
    take_o  = ack_i & req_i & int_en_i & (code_i != '0) & allowed;
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_res_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       ext_lvl_i,
  input  logic [16:0]       softint_i,
  input  logic [3:0]        pil_i,
  input  logic              int_en_i,
  input  logic              v8_mode_i,
  input  logic [2:0]        trap_lvl_i,
  input  logic [8:0]        cur_tt_i,
  input  logic              ack_i,
  output logic [7:0]        code_o,
  output logic              req_o,
  output logic              take_o
);
  logic [NUM_LVL-1:0] pend;
  logic               hit;
  logic [LVL_W-1:0]   win_lvl;
  logic [CODE_W-1:0]  code_q, code_new;
  logic               req_q, take_q, take_d;
  logic               blocked;

  irq_merge i_merge (
    .ext_lvl_i (ext_lvl_i),
    .softint_i (softint_i),
    .pend_o    (pend)
  );

  irq_pick i_pick (
    .pend_i    (pend),
    .pil_i     (pil_i),
    .v8_mode_i (v8_mode_i),
    .hit_o     (hit),
    .lvl_o     (win_lvl)
  );

  irq_gate i_gate (
    .code_i    (code_q),
    .req_i     (req_q),
    .ack_i     (ack_i),
    .int_en_i  (int_en_i),
    .pil_i     (pil_i),
    .v8_mode_i (v8_mode_i),
    .take_o    (take_d)
  );

  assign code_new = {EXT_TT, win_lvl};
  // an outranking trap in service holds off the new request
  assign blocked  = (trap_lvl_i != '0) && (cur_tt_i > TT_W'(code_new));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      req_q  <= 1'b0;
      take_q <= 1'b0;
    end else begin
      take_q <= take_d;
      if (pend == '0) begin
        if (req_q) begin
          code_q <= '0;
          req_q  <= 1'b0;
        end
      end else if (int_en_i && hit && !blocked && (code_new != code_q)) begin
        code_q <= code_new;
        req_q  <= 1'b1;
      end
    end
  end

  assign code_o = code_q;
  assign req_o  = req_q;
  assign take_o = take_q;

  p_req_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (code_o[7:4] == EXT_TT && code_o[3:0] != 4'h0));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_lvl_i[15:1] == '0 && softint_i == '0 && req_o) |=> (!req_o && code_o == 8'h00));

  p_ie_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_en_i && ext_lvl_i[15:1] != '0) |=> ($stable(code_o) && $stable(req_o)));

  p_suppress_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_lvl_i != '0 && cur_tt_i > 9'h04F && ext_lvl_i[15:1] != '0) |=> $stable(code_o));

  p_take_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ($past(ack_i) && $past(req_o)));
endmodule

// File: tb/test_irq_level_resolver.sv
`timescale 1ns/1ps
module test_irq_level_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ext_lvl = '0;
  logic [16:0] softint = '0;
  logic [3:0]  pil = '0;
  logic        ie = 1'b1;
  logic        v8 = 1'b0;
  logic [2:0]  tl = '0;
  logic [8:0]  cur_tt = '0;
  logic        ack = 1'b0;
  logic [7:0]  code;
  logic        req;
  logic        take;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_code = '0;
  logic       m_req  = 1'b0;
  logic       m_take = 1'b0;

  always #4 clk = ~clk;

  irq_level_resolver i_irq_level_resolver (
    .clk_i(clk), .rst_ni(rst_n), .ext_lvl_i(ext_lvl), .softint_i(softint),
    .pil_i(pil), .int_en_i(ie), .v8_mode_i(v8), .trap_lvl_i(tl),
    .cur_tt_i(cur_tt), .ack_i(ack), .code_o(code), .req_o(req), .take_o(take)
  );

  function automatic logic [15:0] f_pend(logic [15:0] e, logic [16:0] s);
    logic [15:0] p;
    p = e | s[15:0];
    p[0] = 1'b0;
    p[14] = p[14] | s[0] | s[16];
    return p;
  endfunction

  function automatic logic f_ok(int lvl, logic [3:0] p, logic v);
    return (lvl > int'(p)) || (v && lvl == 15);
  endfunction

  task automatic chk(input logic [8:0] act, input logic [8:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // advance one edge with model update, then compare all outputs
  task automatic step(input string tag);
    logic [15:0] p;
    int w;
    logic [7:0] nc;
    logic [7:0] c0;
    logic r0;
    c0 = m_code; r0 = m_req;
    p = f_pend(ext_lvl, softint);
    m_take = ack && r0 && ie && c0 != 0 && f_ok(int'(c0[3:0]), pil, v8);
    if (p == 0) begin
      if (r0) begin m_code = 0; m_req = 0; end
    end else if (ie) begin
      w = 0;
      for (int i = 15; i >= 1; i--)
        if (w == 0 && p[i] && f_ok(i, pil, v8)) w = i;
      nc = 8'h40 | 8'(w);
      if (w != 0 && !(tl != 0 && cur_tt > {1'b0, nc}) && nc != c0) begin
        m_code = nc; m_req = 1;
      end
    end
    @(posedge clk);
    #2;
    chk({1'b0, code}, {1'b0, m_code}, tag);
    chk({8'b0, req}, {8'b0, m_req}, tag);
    chk({8'b0, take}, {8'b0, m_take}, tag);
  endtask

  task automatic idle();
    ext_lvl = '0; softint = '0; pil = '0; ie = 1; v8 = 0; tl = '0; cur_tt = '0; ack = 0;
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    @(posedge clk); #2;
    chk({1'b0, code}, 9'h000, "R1");
    chk({8'b0, req}, 9'h0, "R1");
    chk({8'b0, take}, 9'h0, "R1");
    @(negedge clk); rst_n = 1'b1; #1;

    ext_lvl = 16'h0020; step("R4");
    chk({1'b0, code}, 9'h045, "R4");
    ext_lvl = 16'h0208; step("R4");
    chk({1'b0, code}, 9'h049, "R4");
    ext_lvl = 16'h0001; step("R2");
    chk({1'b0, code}, 9'h000, "R2");
    chk({8'b0, req}, 9'h0, "R8");
    ext_lvl = 0; softint = 17'h00080; step("R2");
    chk({1'b0, code}, 9'h047, "R2");
    softint = 17'h10000; step("R3");
    chk({1'b0, code}, 9'h04E, "R3");
    softint = 0; step("R8");
    chk({8'b0, req}, 9'h0, "R8");
    softint = 17'h00001; step("R3");
    chk({1'b0, code}, 9'h04E, "R3");
    softint = 0; step("R8");

    pil = 4'hF; ext_lvl = 16'h8000; v8 = 0; step("R5");
    chk({1'b0, code}, 9'h000, "R5");
    v8 = 1; step("R5");
    chk({1'b0, code}, 9'h04F, "R5");
    ack = 1; step("R9");
    step("R9");
    chk({8'b0, take}, 9'h1, "R9");
    v8 = 0; step("R9");
    chk({8'b0, take}, 9'h0, "R9");
    idle(); step("R8");

    pil = 4'd9; ext_lvl = 16'h0200; step("R10");
    chk({8'b0, req}, 9'h0, "R10");
    pil = 4'd8; step("R4");
    chk({1'b0, code}, 9'h049, "R4");
    ie = 0; ext_lvl = 16'h1000; step("R6");
    chk({1'b0, code}, 9'h049, "R6");
    ack = 1; step("R9");
    step("R9");
    chk({8'b0, take}, 9'h0, "R9");
    ack = 0; ie = 1; tl = 3'd1; cur_tt = 9'h050; step("R7");
    chk({1'b0, code}, 9'h049, "R7");
    cur_tt = 9'h04C; step("R7");
    chk({1'b0, code}, 9'h04C, "R7");
    tl = 0; cur_tt = 9'h1FF; ext_lvl = 16'h2000; step("R7");
    chk({1'b0, code}, 9'h04D, "R7");
    idle(); step("R8");

    for (int n = 0; n < 3000; n++) begin
      ext_lvl = 16'($urandom) & 16'($urandom) & 16'($urandom);
      softint = 17'($urandom) & 17'($urandom) & 17'($urandom) & 17'($urandom);
      if ($urandom_range(0, 7) == 0) begin ext_lvl = 0; softint = 0; end
      pil = 4'($urandom);
      ie = ($urandom_range(0, 5) != 0);
      v8 = 1'($urandom);
      tl = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd0;
      cur_tt = 9'($urandom_range(0, 9'h0A0));
      ack = 1'($urandom);
      step("R4");
    end

    @(negedge clk); rst_n = 1'b0; #1;
    chk({1'b0, code}, 9'h000, "R1");
    chk({8'b0, req}, 9'h0, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule